// File: doc/BRIEF.md
# Raster Readout Sync Timing Generator

This block times the readout of a pixel array organised as a raster of lines. From a fast system clock it derives a pixel-slot enable at one quarter of that rate. It counts columns within a line and lines within a frame, and it produces the line sync, the frame sync and a per-pixel strobe with window-relative coordinates. A downstream data path uses the strobe to decide which pixels to keep.

Every line begins with a blanking stretch whose length is an odd number of pixel slots, computed from a halved register value. The active columns of the array follow it. Every frame begins with a fixed number of dark rows, followed by the valid rows, and its length in lines comes from a register. A rectangular window and a decimation ratio (full, 1/2, 1/4 or 1/16, applied to both axes) select the pixels that get a strobe. The configuration inputs are captured while reset is held and again at each frame boundary, so a frame never mixes two settings.

Top module: `sensor_sync_gen`

## Requirements
- R1: `pclk_en` is high for exactly one system clock in every `CLK_DIV` (default 4). All counters and outputs change only on system clock edges where `pclk_en` is high.
- R2: A line lasts `2*cfg_blank_half + 1 + ACT_COLS` pixel slots. The first `2*cfg_blank_half + 1` slots are blanking and the rest are active columns, numbered 0 upward.
- R3: A frame lasts `cfg_last_line + 1` lines. `vsync` is high for every slot of line 0 and low on all other lines.
- R4: Lines 0 to `DARK_ROWS-1` (default 4) are dark rows. `pix_strobe` is never high on a dark row.
- R5: When `cfg_hide_dark` is 1, `hsync` stays low for the whole of every dark row. When it is 0, dark rows carry `hsync` like any other line.
- R6: On every line that R5 does not suppress, `hsync` is high exactly during the active-column slots and low during blanking.
- R7: Let x be the active column. A pixel can strobe only when `cfg_col_start <= x <= cfg_col_start + cfg_col_span`. A window that runs past the last column is clipped there.
- R8: Let y be the valid-row index, which is line number minus `DARK_ROWS`. A pixel can strobe only when `cfg_row_start <= y <= cfg_row_start + cfg_row_span`.
- R9: `cfg_decim` selects the ratio r: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 16. A window pixel strobes only if `(x - cfg_col_start)` and `(y - cfg_row_start)` are both multiples of r. It then reports `pix_col = (x - cfg_col_start)/r` and `pix_row = (y - cfg_row_start)/r`. `pix_strobe` is high only together with `pclk_en`.
- R10: The configuration inputs take effect only at the start of the frame that follows the change. A change in the middle of a frame leaves the rest of that frame untouched.
- R11: While `rst` is high, `pclk_en`, `hsync` and `pix_strobe` are low and `vsync` is high, because the counters sit at line 0, column slot 0. The configuration present during reset governs the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blank_half | input | 8 | Half of the line blanking length; blanking is 2N+1 slots |
| cfg_last_line | input | 9 | Index of the last line of a frame (frame = value + 1 lines) |
| cfg_hide_dark | input | 1 | 1 suppresses hsync on dark rows |
| cfg_col_start | input | 10 | First active column of the window |
| cfg_row_start | input | 9 | First valid row of the window |
| cfg_col_span | input | 10 | Window width minus one, in columns |
| cfg_row_span | input | 9 | Window height minus one, in valid rows |
| cfg_decim | input | 2 | Decimation code: 0 full, 1 half, 2 quarter, 3 sixteenth |
| pclk_en | output | 1 | Pixel-slot enable, one system clock in CLK_DIV |
| hsync | output | 1 | Line sync, high over the active columns of enabled lines |
| vsync | output | 1 | Frame sync, high for the whole first line |
| pix_strobe | output | 1 | Window pixel kept after decimation, coincident with pclk_en |
| pix_col | output | 10 | Decimated column index inside the window |
| pix_row | output | 9 | Decimated row index inside the window |

## Verification
The bench goes after the frame boundary. It changes settings in the middle of a frame, including the dark-row sync mask while the dark rows are being read out. A design that applied registers at once would then show a wrong hsync count in the dark rows or a line of the wrong length. It also drives windows that touch or pass the right edge of the array, offset windows combined with 1/4 and 1/16 decimation, the shortest blanking of one slot, and a frame with a single valid row. These cases catch off-by-one window bounds, a phase taken from the array origin instead of the window origin, and a blank length computed as 2N instead of 2N+1. The line period and the frame period are measured independently from the rises of hsync and vsync.

// File: rtl/sensor_sync_pkg.sv
package sensor_sync_pkg;

    localparam int BLANK_W = 8;
    localparam int COL_W   = 10;
    localparam int ROW_W   = 9;
    localparam int DECIM_W = 2;
    localparam int CNT_W   = COL_W + 2;
    localparam int SHIFT_W = 3;

    typedef struct packed {
        logic [BLANK_W-1:0] blank_half;
        logic [ROW_W-1:0]   last_line;
        logic               hide_dark;
        logic [COL_W-1:0]   col_start;
        logic [ROW_W-1:0]   row_start;
        logic [COL_W-1:0]   col_span;
        logic [ROW_W-1:0]   row_span;
        logic [DECIM_W-1:0] decim;
    } sync_cfg_t;

    typedef struct packed {
        logic             hsync;
        logic             vsync;
        logic             strobe;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pix_out_t;

    typedef enum logic [DECIM_W-1:0] {
        DECIM_FULL  = 2'd0,
        DECIM_HALF  = 2'd1,
        DECIM_QUART = 2'd2,
        DECIM_SIXTN = 2'd3
    } decim_e;

    function automatic logic [BLANK_W:0] blank_len(input logic [BLANK_W-1:0] half);
        return {half, 1'b1};
    endfunction

    function automatic logic [SHIFT_W-1:0] decim_shift(input logic [DECIM_W-1:0] sel);
        case (decim_e'(sel))
            DECIM_FULL:  return 3'd0;
            DECIM_HALF:  return 3'd1;
            DECIM_QUART: return 3'd2;
            default:     return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/st_pix_div.sv
module st_pix_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic pclk_en
);
    localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst)               dcnt <= '0;
        else if (dcnt == LAST) dcnt <= '0;
        else                   dcnt <= dcnt + 1'b1;
    end

    assign pclk_en = (dcnt == LAST);

    // R1: an enable is always followed by at least one idle cycle
    assert_en_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        pclk_en |=> !pclk_en);

endmodule

// File: rtl/st_cfg_shadow.sv
module st_cfg_shadow
    import sensor_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  sync_cfg_t cfg_in,
    output sync_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || load) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/st_raster_cnt.sv
module st_raster_cnt
    import sensor_sync_pkg::*;
#(
    parameter int ACT_COLS = 644
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pclk_en,
    input  logic [BLANK_W-1:0] blank_half,
    input  logic [ROW_W-1:0]   last_line,
    output logic [CNT_W-1:0]   hcnt,
    output logic [ROW_W-1:0]   vcnt,
    output logic               frame_end
);
    localparam logic [CNT_W-1:0] ACT_M1 = CNT_W'(ACT_COLS - 1);

    logic [CNT_W-1:0] line_last;
    logic             line_end;

    assign line_last = CNT_W'(blank_len(blank_half)) + ACT_M1;
    assign line_end  = (hcnt == line_last);
    assign frame_end = pclk_en && line_end && (vcnt == last_line);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (pclk_en) begin
            if (line_end) begin
                hcnt <= '0;
                vcnt <= (vcnt == last_line) ? '0 : vcnt + 1'b1;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R2: the column counter restarts after the last slot of a line
    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && line_end) |=> (hcnt == '0));

    // R1: counters only move on enabled slots
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !pclk_en |=> ($stable(hcnt) && $stable(vcnt)));

    // R3: line number never passes the programmed last line
    assert_row_bound_R3: assert property (@(posedge clk) disable iff (rst)
        vcnt <= last_line);

endmodule

// File: rtl/st_pix_gate.sv
module st_pix_gate
    import sensor_sync_pkg::*;
#(
    parameter int ACT_COLS  = 644,
    parameter int DARK_ROWS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pclk_en,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [ROW_W-1:0] vcnt,
    input  sync_cfg_t        cfg,
    output pix_out_t         pix
);
    localparam int RW = ROW_W + 1;
    localparam logic [ROW_W-1:0] DARK_N = ROW_W'(DARK_ROWS);

    logic [CNT_W-1:0]   blen, xpos, c0, chi, dx, xmask;
    logic [RW-1:0]      vy, r0, rhi, dy, ymask;
    logic [SHIFT_W-1:0] sh;
    logic               active, dark, col_ok, row_ok, phase_ok, hit;

    always_comb begin
        blen   = CNT_W'(blank_len(cfg.blank_half));
        active = (hcnt >= blen);
        xpos   = hcnt - blen;
        dark   = (vcnt < DARK_N);
        vy     = RW'(vcnt) - RW'(DARK_ROWS);

        c0     = CNT_W'(cfg.col_start);
        chi    = c0 + CNT_W'(cfg.col_span);
        col_ok = (xpos >= c0) && (xpos <= chi);
        dx     = xpos - c0;

        r0     = RW'(cfg.row_start);
        rhi    = r0 + RW'(cfg.row_span);
        row_ok = (vy >= r0) && (vy <= rhi);
        dy     = vy - r0;

        sh       = decim_shift(cfg.decim);
        xmask    = (CNT_W'(1) << sh) - CNT_W'(1);
        ymask    = (RW'(1) << sh) - RW'(1);
        phase_ok = ((dx & xmask) == '0) && ((dy & ymask) == '0);

        hit = active && !dark && col_ok && row_ok && phase_ok;

        pix.hsync  = active && !(dark && cfg.hide_dark);
        pix.vsync  = (vcnt == '0);
        pix.strobe = hit && pclk_en;
        pix.col    = COL_W'(dx >> sh);
        pix.row    = ROW_W'(dy >> sh);
    end

    // R4: no pixel is reported on a dark row
    assert_dark_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (vcnt < DARK_N) |-> !pix.strobe);

    // R5: masked dark rows carry no line sync
    assert_hide_dark_R5: assert property (@(posedge clk) disable iff (rst)
        ((vcnt < DARK_N) && cfg.hide_dark) |-> !pix.hsync);

    // R6: a reported pixel always lies inside the line sync
    assert_strobe_in_line_R6: assert property (@(posedge clk) disable iff (rst)
        pix.strobe |-> pix.hsync);

    // R3: frame sync begins at the first slot of a line
    assert_vsync_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pix.vsync) |-> (hcnt == '0));

    // R7: decimated column stays within the window width
    assert_col_window_R7: assert property (@(posedge clk) disable iff (rst)
        pix.strobe |-> (pix.col <= cfg.col_span));

    // R8: decimated row stays within the window height
    assert_row_window_R8: assert property (@(posedge clk) disable iff (rst)
        pix.strobe |-> (pix.row <= cfg.row_span));

endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen
    import sensor_sync_pkg::*;
#(
    parameter int ACT_COLS  = 644,
    parameter int DARK_ROWS = 4,
    parameter int CLK_DIV   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BLANK_W-1:0] cfg_blank_half,
    input  logic [ROW_W-1:0]   cfg_last_line,
    input  logic               cfg_hide_dark,
    input  logic [COL_W-1:0]   cfg_col_start,
    input  logic [ROW_W-1:0]   cfg_row_start,
    input  logic [COL_W-1:0]   cfg_col_span,
    input  logic [ROW_W-1:0]   cfg_row_span,
    input  logic [DECIM_W-1:0] cfg_decim,
    output logic               pclk_en,
    output logic               hsync,
    output logic               vsync,
    output logic               pix_strobe,
    output logic [COL_W-1:0]   pix_col,
    output logic [ROW_W-1:0]   pix_row
);
    sync_cfg_t        cfg_in, cfg_q;
    logic [CNT_W-1:0] hcnt;
    logic [ROW_W-1:0] vcnt;
    logic             frame_end;
    pix_out_t         pix;

    always_comb begin
        cfg_in.blank_half = cfg_blank_half;
        cfg_in.last_line  = cfg_last_line;
        cfg_in.hide_dark  = cfg_hide_dark;
        cfg_in.col_start  = cfg_col_start;
        cfg_in.row_start  = cfg_row_start;
        cfg_in.col_span   = cfg_col_span;
        cfg_in.row_span   = cfg_row_span;
        cfg_in.decim      = cfg_decim;
    end

    st_pix_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .pclk_en (pclk_en)
    );

    st_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_end),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    st_raster_cnt #(.ACT_COLS(ACT_COLS)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .pclk_en    (pclk_en),
        .blank_half (cfg_q.blank_half),
        .last_line  (cfg_q.last_line),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .frame_end  (frame_end)
    );

    st_pix_gate #(.ACT_COLS(ACT_COLS), .DARK_ROWS(DARK_ROWS)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .pclk_en (pclk_en),
        .hcnt    (hcnt),
        .vcnt    (vcnt),
        .cfg     (cfg_q),
        .pix     (pix)
    );

    assign hsync      = pix.hsync;
    assign vsync      = pix.vsync;
    assign pix_strobe = pix.strobe;
    assign pix_col    = pix.col;
    assign pix_row    = pix.row;

    // R10: the working configuration moves only at a frame boundary
    assert_cfg_frame_only_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_q));

    // R10: at a boundary the new frame restarts from line 0
    assert_boundary_restart_R10: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (vcnt == '0) && (hcnt == '0));

endmodule

// File: tb/tb_sensor_sync_gen.sv
module tb_sensor_sync_gen;
    localparam int ACT  = 24;
    localparam int DARK = 4;
    localparam int DIV  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_blank_half;
    logic [8:0] cfg_last_line;
    logic       cfg_hide_dark;
    logic [9:0] cfg_col_start;
    logic [8:0] cfg_row_start;
    logic [9:0] cfg_col_span;
    logic [8:0] cfg_row_span;
    logic [1:0] cfg_decim;
    logic       pclk_en, hsync, vsync, pix_strobe;
    logic [9:0] pix_col;
    logic [8:0] pix_row;

    always #2 clk = ~clk;

    sensor_sync_gen #(.ACT_COLS(ACT), .DARK_ROWS(DARK), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst),
        .cfg_blank_half(cfg_blank_half), .cfg_last_line(cfg_last_line),
        .cfg_hide_dark(cfg_hide_dark), .cfg_col_start(cfg_col_start),
        .cfg_row_start(cfg_row_start), .cfg_col_span(cfg_col_span),
        .cfg_row_span(cfg_row_span), .cfg_decim(cfg_decim),
        .pclk_en(pclk_en), .hsync(hsync), .vsync(vsync),
        .pix_strobe(pix_strobe), .pix_col(pix_col), .pix_row(pix_row)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct {
        bit hs;
        bit vs;
        bit st;
        int col;
        int row;
        bit dark;
    } exp_t;
    exp_t sb_q[$];

    // model state
    int mb, ml, mc0, mr0, mcs, mrs, md;
    bit mhide;
    int m_h, m_v, frames, line_idx;
    int gap;
    bit seen_en, prev_hs, prev_vs, have_vs;
    int hs_slots, vs_slots, last_rise_line, prev_frame_len, dark_hs;

    task automatic load_model_cfg();
        mb    = int'(cfg_blank_half);
        ml    = int'(cfg_last_line);
        mhide = cfg_hide_dark;
        mc0   = int'(cfg_col_start);
        mr0   = int'(cfg_row_start);
        mcs   = int'(cfg_col_span);
        mrs   = int'(cfg_row_span);
        md    = int'(cfg_decim);
    endtask

    // reference process: predicts each pixel slot and pushes it to the scoreboard
    task automatic predict_slot();
        exp_t e;
        int bl, x, vy, sh, r;
        bit act;
        bl  = 2 * mb + 1;
        act = (m_h >= bl);
        x   = m_h - bl;
        vy  = m_v - DARK;
        sh  = (md == 3) ? 4 : md;
        r   = 1 << sh;
        e.dark = (m_v < DARK);
        e.hs   = act && !(e.dark && mhide);
        e.vs   = (m_v == 0);
        e.st   = act && !e.dark && (x >= mc0) && (x <= mc0 + mcs) &&
                 (vy >= mr0) && (vy <= mr0 + mrs) &&
                 ((x - mc0) % r == 0) && ((vy - mr0) % r == 0);
        e.col  = e.st ? (x - mc0) / r : 0;
        e.row  = e.st ? (vy - mr0) / r : 0;
        sb_q.push_back(e);
    endtask

    // monitor: pops the prediction and compares with the outputs
    always @(negedge clk) begin
        if (rst) begin
            load_model_cfg();
            m_h = 0; m_v = 0; line_idx = 0; gap = 0;
            seen_en = 0; prev_hs = 0; prev_vs = 0; have_vs = 0;
            hs_slots = 0; vs_slots = 0; last_rise_line = -10; dark_hs = 0;
            sb_q.delete();
        end else begin
            gap++;
            if (pix_strobe && !pclk_en)
                chk(1'b0, "R9 strobe without pclk_en", 1, 0);
            if (pclk_en) begin
                exp_t g;
                int bl;
                if (seen_en) chk(gap == DIV, "R1 enable period", gap, DIV);
                seen_en = 1; gap = 0;
                bl = 2 * mb + 1;
                predict_slot();
                g = sb_q.pop_front();
                if (g.dark) chk(hsync == g.hs, "R5 hsync on dark row", int'(hsync), int'(g.hs));
                else        chk(hsync == g.hs, "R6 hsync", int'(hsync), int'(g.hs));
                chk(vsync == g.vs, "R3 vsync", int'(vsync), int'(g.vs));
                if (g.dark) chk(pix_strobe == g.st, "R4 dark strobe", int'(pix_strobe), int'(g.st));
                else        chk(pix_strobe == g.st, "R7 R8 window strobe", int'(pix_strobe), int'(g.st));
                if (g.st && pix_strobe) begin
                    chk(int'(pix_col) == g.col, "R9 pix_col", int'(pix_col), g.col);
                    chk(int'(pix_row) == g.row, "R9 pix_row", int'(pix_row), g.row);
                end
                // line period from hsync rises (R2)
                hs_slots++;
                if (hsync && !prev_hs) begin
                    if (last_rise_line == line_idx - 1)
                        chk(hs_slots == ACT + bl, "R2 line period", hs_slots, ACT + bl);
                    last_rise_line = line_idx;
                    hs_slots = 0;
                end
                // frame period from vsync rises (R3)
                vs_slots++;
                if (vsync && !prev_vs) begin
                    if (have_vs)
                        chk(vs_slots == prev_frame_len, "R3 frame period", vs_slots, prev_frame_len);
                    have_vs = 1;
                    vs_slots = 0;
                end
                if ((m_v < DARK) && hsync) dark_hs++;
                prev_hs = hsync;
                prev_vs = vsync;
                // advance model
                if (m_h == bl + ACT - 1) begin
                    m_h = 0;
                    line_idx++;
                    if (m_v == ml) begin
                        int nd, ed;
                        nd = (ml + 1 < DARK) ? ml + 1 : DARK;
                        ed = mhide ? 0 : nd * ACT;
                        chk(dark_hs == ed, "R10 dark-row hsync of frame setting", dark_hs, ed);
                        dark_hs = 0;
                        prev_frame_len = (ml + 1) * (bl + ACT);
                        m_v = 0;
                        frames++;
                        load_model_cfg();
                    end else begin
                        m_v++;
                    end
                end else begin
                    m_h++;
                end
            end
        end
    end

    task automatic set_cfg(input int b, input int l, input bit h, input int c0,
                           input int r0, input int cs, input int rs, input int d);
        @(posedge clk); #1;
        cfg_blank_half = 8'(b);
        cfg_last_line  = 9'(l);
        cfg_hide_dark  = h;
        cfg_col_start  = 10'(c0);
        cfg_row_start  = 9'(r0);
        cfg_col_span   = 10'(cs);
        cfg_row_span   = 9'(rs);
        cfg_decim      = 2'(d);
    endtask

    task automatic run_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: idle outputs during reset
        chk(pclk_en == 1'b0, "R11 pclk_en in reset", int'(pclk_en), 0);
        chk(vsync == 1'b1, "R11 vsync in reset", int'(vsync), 1);
        chk(hsync == 1'b0, "R11 hsync in reset", int'(hsync), 0);
        chk(pix_strobe == 1'b0, "R11 strobe in reset", int'(pix_strobe), 0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        frames = 0;
        cfg_blank_half = 8'd2;  cfg_last_line = 9'd13; cfg_hide_dark = 1'b0;
        cfg_col_start = 10'd0;  cfg_row_start = 9'd0;
        cfg_col_span = 10'd643; cfg_row_span = 9'd487; cfg_decim = 2'd0;
        do_reset();
        run_frames(2);
        // R5: dark rows masked
        set_cfg(2, 13, 1, 0, 0, 643, 487, 0);   run_frames(2);
        // R7 R8: interior window
        set_cfg(3, 13, 0, 5, 2, 9, 5, 0);       run_frames(2);
        // R7: window clipped at the right edge
        set_cfg(1, 13, 0, 20, 0, 10, 3, 0);     run_frames(2);
        // R9: half decimation
        set_cfg(2, 15, 0, 0, 0, 643, 487, 1);   run_frames(2);
        // R9: quarter decimation from an offset window
        set_cfg(2, 17, 1, 3, 1, 20, 12, 2);     run_frames(2);
        // R9: sixteenth decimation
        set_cfg(0, 25, 0, 0, 0, 643, 487, 3);   run_frames(2);
        // R2 R4: shortest blank, single valid row
        set_cfg(0, 4, 0, 0, 0, 643, 487, 0);    run_frames(2);
        // R10: mask changed while dark rows are being read
        set_cfg(4, 11, 0, 0, 0, 643, 487, 0);   run_frames(1);
        while (!(m_v == 1 && m_h == 2)) @(posedge clk);
        set_cfg(1, 9, 1, 2, 1, 7, 3, 1);        run_frames(2);
        // R10: frame shorter than the dark rows
        set_cfg(2, 2, 0, 0, 0, 643, 487, 0);    run_frames(2);
        // R11: configuration held during reset governs the first frame
        cfg_blank_half = 8'd1; cfg_last_line = 9'd7; cfg_hide_dark = 1'b1;
        cfg_col_start = 10'd4; cfg_row_start = 9'd0;
        cfg_col_span = 10'd5;  cfg_row_span = 9'd2; cfg_decim = 2'd0;
        do_reset();
        run_frames(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", frames, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule